// File: doc/BRIEF.md
# Clock Buffer Control Register Bank

This block holds the control state of a multi-output differential clock buffer. It sits behind a slave register port of a two-wire management bus. The port controller hands it single-register writes and combinational reads. There are three 8-bit registers. The first is a control register. It carries the frequency-select strap and a copy of the PLL-mode strap, both captured at power-up, plus a software override for the PLL mode and an enable for that override. The other two registers hold one enable bit for each of twelve clock outputs.

The PLL-mode strap and the frequency-select strap are sampled once, at the first clock after power-on reset is released, and stay frozen until the next power-on reset. The effective PLL mode starts at the strap value. After that it changes only when a warm-reset pulse arrives. On that pulse it takes either the latched strap or the software bits, chosen by the override enable. The frequency select, the effective mode and the output-enable vector go to the rest of the chip. A disabled output is parked. A build option chooses whether parking means high impedance or both legs driven low.

Top module: `clkbuf_ctrl_regs`

## Requirements
- R1: While power-on reset is asserted and after its release, the register bank holds its defaults. Control register (address 0) bits 2:1 read 2'b11 and bit 3 reads 0. Every output-enable bit reads 1 and oe_o is all ones.
- R2: Address 0 bit 0 reads the latched frequency strap (1 = 100 MHz, 0 = 133 MHz), and fs_sel_o equals it. Writes to this bit are ignored.
- R3: Both straps are captured at the first rising clock edge after rst_ni goes high. Later changes on strap_fs_i or strap_mode_i have no effect until the next power-on reset.
- R4: Address 0 bits 7:6 always read the latched PLL-mode strap, including while the software override is enabled. Writes to them are ignored.
- R5: Address 0 bits 5:4 and address 2 bits 7:4 read 0, and writes to them are ignored. Address 3 reads 0x00 and writes to it change nothing.
- R6: pll_mode_o takes the strap value in the capture cycle. After that it changes only in the cycle after a clock edge with warm_rst_i high. It then becomes the software mode (bits 2:1) if the override enable (bit 3) was 1, and the latched strap mode otherwise.
- R7: A write to address 0 with reg_we_i high updates bits 3:1 at that clock edge, and the new value reads back on the following cycle.
- R8: Address 1 bit k drives oe_o[k] for k = 0..7, and address 2 bit j drives oe_o[8+j] for j = 0..3. A bit value of 1 means enabled.
- R9: With the default build option (high impedance), park_hiz_o[i] is the inverse of oe_o[i] and park_low_o is all zeros. The two park vectors are never both high for one output, and neither is high for an enabled output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, asynchronous, active low |
| warm_rst_i | input | 1 | Warm-reset pulse; applies the selected PLL mode |
| strap_fs_i | input | 1 | Frequency-select strap pin level |
| strap_mode_i | input | 2 | PLL-mode strap pin levels |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i (combinational) |
| fs_sel_o | output | 1 | Latched frequency select |
| pll_mode_o | output | 2 | Effective PLL mode |
| oe_o | output | 12 | Output enables, 1 = enabled |
| park_hiz_o | output | 12 | Park output in high impedance |
| park_low_o | output | 12 | Park output with both legs low |

## Verification
The hardest state to reach is one where the software override bits, the override enable and the frozen strap all disagree with each other and with the strap pins at the moment a warm-reset pulse lands. Only in that state does an exchange of sources in the mode mux become visible. The stimulus first captures one strap value and then drives different levels on the strap pins. It then writes a software mode different from the strap and toggles the enable between warm-reset pulses. It checks that readback bits 7:6 keep the captured value throughout. A long run of random writes, warm pulses and pin changes follows, compared every clock against a behavioural model. A second power-on reset with other strap levels shows that recapture works.

// File: rtl/clkbuf_ctrl_pkg.sv
package clkbuf_ctrl_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned FS_BIT    = 0;
  localparam int unsigned SWM_LSB   = 1;
  localparam int unsigned SWEN_BIT  = 3;
  localparam int unsigned STRAP_LSB = 6;

  typedef struct packed {
    logic [1:0] mode;
    logic       fs;
  } strap_t;
endpackage

// File: rtl/clkbuf_strap_latch.sv
module clkbuf_strap_latch
  import clkbuf_ctrl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fs_i,
  input  logic [1:0] mode_i,
  output logic       done_o,
  output strap_t     strap_o
);
  logic   done_q;
  strap_t strap_q;

  // one-shot capture on the first edge after power-on reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      strap_q <= '0;
    end else if (!done_q) begin
      done_q       <= 1'b1;
      strap_q.fs   <= fs_i;
      strap_q.mode <= mode_i;
    end
  end

  assign done_o  = done_q;
  assign strap_o = strap_q;
endmodule

// File: rtl/clkbuf_reg_file.sv
module clkbuf_reg_file
  import clkbuf_ctrl_pkg::*;
#(
  parameter  int unsigned N_OUT = 12,
  localparam int unsigned NOE   = (N_OUT + REG_W - 1) / REG_W,
  localparam int unsigned AW    = $clog2(NOE + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  strap_t           strap_i,
  output logic [1:0]       sw_mode_o,
  output logic             sw_en_o,
  output logic [N_OUT-1:0] oe_o,
  output logic [REG_W-1:0] rdata_o
);
  localparam int unsigned PAD_W = NOE * REG_W;

  logic [1:0]       sw_mode_q;
  logic             sw_en_q;
  logic [PAD_W-1:0] oe_pad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_mode_q <= 2'b11;
      sw_en_q   <= 1'b0;
    end else if (we_i && addr_i == '0) begin
      sw_mode_q <= wdata_i[SWM_LSB +: 2];
      sw_en_q   <= wdata_i[SWEN_BIT];
    end
  end

  for (genvar i = 0; i < N_OUT; i++) begin : g_oe
    localparam int unsigned REG_IDX = 1 + i / REG_W;
    localparam int unsigned BIT_IDX = i % REG_W;
    logic en_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                en_q <= 1'b1;
      else if (we_i && addr_i == AW'(REG_IDX))    en_q <= wdata_i[BIT_IDX];
    end
    assign oe_o[i] = en_q;
  end

  if (PAD_W > N_OUT) begin : g_pad
    assign oe_pad = {{(PAD_W - N_OUT){1'b0}}, oe_o};
  end else begin : g_nopad
    assign oe_pad = oe_o;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == '0) begin
      rdata_o[FS_BIT]            = strap_i.fs;
      rdata_o[SWM_LSB +: 2]      = sw_mode_q;
      rdata_o[SWEN_BIT]          = sw_en_q;
      rdata_o[STRAP_LSB +: 2]    = strap_i.mode;
    end else begin
      for (int k = 1; k <= int'(NOE); k++) begin
        if (addr_i == AW'(k)) rdata_o = oe_pad[(k-1)*REG_W +: REG_W];
      end
    end
  end

  assign sw_mode_o = sw_mode_q;
  assign sw_en_o   = sw_en_q;
endmodule

// File: rtl/clkbuf_mode_select.sv
module clkbuf_mode_select (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       done_i,
  input  logic [1:0] strap_raw_i,
  input  logic [1:0] strap_q_i,
  input  logic       warm_i,
  input  logic       sw_en_i,
  input  logic [1:0] sw_mode_i,
  output logic [1:0] mode_o
);
  logic [1:0] mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= 2'b00;
    else if (!done_i) mode_q <= strap_raw_i;  // capture cycle
    else if (warm_i)  mode_q <= sw_en_i ? sw_mode_i : strap_q_i;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/clkbuf_out_park.sv
module clkbuf_out_park #(
  parameter int unsigned N_OUT    = 12,
  parameter bit          PARK_HIZ = 1'b1
) (
  input  logic [N_OUT-1:0] oe_i,
  output logic [N_OUT-1:0] hiz_o,
  output logic [N_OUT-1:0] low_o
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    if (PARK_HIZ) begin : g_hiz
      assign hiz_o[i] = ~oe_i[i];
      assign low_o[i] = 1'b0;
    end else begin : g_low
      assign hiz_o[i] = 1'b0;
      assign low_o[i] = ~oe_i[i];
    end
  end
endmodule

// File: rtl/clkbuf_ctrl_regs.sv
module clkbuf_ctrl_regs
  import clkbuf_ctrl_pkg::*;
#(
  parameter  int unsigned N_OUT    = 12,
  parameter  bit          PARK_HIZ = 1'b1,
  localparam int unsigned NOE      = (N_OUT + REG_W - 1) / REG_W,
  localparam int unsigned AW       = $clog2(NOE + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             warm_rst_i,
  input  logic             strap_fs_i,
  input  logic [1:0]       strap_mode_i,
  input  logic             reg_we_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             fs_sel_o,
  output logic [1:0]       pll_mode_o,
  output logic [N_OUT-1:0] oe_o,
  output logic [N_OUT-1:0] park_hiz_o,
  output logic [N_OUT-1:0] park_low_o
);
  logic       cap_done;
  strap_t     strap_q;
  logic [1:0] sw_mode;
  logic       sw_en;

  clkbuf_strap_latch u_strap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fs_i    (strap_fs_i),
    .mode_i  (strap_mode_i),
    .done_o  (cap_done),
    .strap_o (strap_q)
  );

  clkbuf_reg_file #(.N_OUT(N_OUT)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .strap_i   (strap_q),
    .sw_mode_o (sw_mode),
    .sw_en_o   (sw_en),
    .oe_o      (oe_o),
    .rdata_o   (reg_rdata_o)
  );

  clkbuf_mode_select u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .done_i      (cap_done),
    .strap_raw_i (strap_mode_i),
    .strap_q_i   (strap_q.mode),
    .warm_i      (warm_rst_i),
    .sw_en_i     (sw_en),
    .sw_mode_i   (sw_mode),
    .mode_o      (pll_mode_o)
  );

  clkbuf_out_park #(.N_OUT(N_OUT), .PARK_HIZ(PARK_HIZ)) u_park (
    .oe_i  (oe_o),
    .hiz_o (park_hiz_o),
    .low_o (park_low_o)
  );

  assign fs_sel_o = strap_q.fs;
endmodule

// File: rtl/clkbuf_ctrl_regs_chk.sv
module clkbuf_ctrl_regs_chk #(
  parameter int unsigned N_OUT = 12,
  parameter int unsigned AW    = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             warm_rst_i,
  input logic             cap_done,
  input logic [1:0]       strap_mode_q,
  input logic             sw_en,
  input logic [1:0]       sw_mode,
  input logic [AW-1:0]    reg_addr_i,
  input logic [7:0]       reg_rdata_o,
  input logic             fs_sel_o,
  input logic [1:0]       pll_mode_o,
  input logic [N_OUT-1:0] oe_o,
  input logic [N_OUT-1:0] park_hiz_o,
  input logic [N_OUT-1:0] park_low_o
);
  // R3
  strap_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_done && $past(cap_done)) |-> ($stable(fs_sel_o) && $stable(strap_mode_q)));

  // R6
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cap_done) && !$past(warm_rst_i)) |-> $stable(pll_mode_o));

  // R6
  mode_apply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cap_done) && $past(warm_rst_i)) |->
      (pll_mode_o == ($past(sw_en) ? $past(sw_mode) : strap_mode_q)));

  // R4
  strap_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_done && reg_addr_i == '0) |-> (reg_rdata_o[7:6] == strap_mode_q));

  // R5
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == '0) |-> (reg_rdata_o[5:4] == 2'b00));

  // R9
  park_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((park_hiz_o & park_low_o) | ((park_hiz_o | park_low_o) & oe_o)) == '0));
endmodule

bind clkbuf_ctrl_regs clkbuf_ctrl_regs_chk #(.N_OUT(N_OUT), .AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .warm_rst_i   (warm_rst_i),
  .cap_done     (cap_done),
  .strap_mode_q (strap_q.mode),
  .sw_en        (sw_en),
  .sw_mode      (sw_mode),
  .reg_addr_i   (reg_addr_i),
  .reg_rdata_o  (reg_rdata_o),
  .fs_sel_o     (fs_sel_o),
  .pll_mode_o   (pll_mode_o),
  .oe_o         (oe_o),
  .park_hiz_o   (park_hiz_o),
  .park_low_o   (park_low_o)
);

// File: tb/clkbuf_ctrl_regs_test.sv
module clkbuf_ctrl_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        warm = 1'b0;
  logic        s_fs = 1'b0;
  logic [1:0]  s_mode = 2'b00;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'b00;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic        fs_o;
  logic [1:0]  mode_o;
  logic [11:0] oe, hiz, low;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  clkbuf_ctrl_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .warm_rst_i(warm), .strap_fs_i(s_fs),
    .strap_mode_i(s_mode), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .fs_sel_o(fs_o), .pll_mode_o(mode_o), .oe_o(oe),
    .park_hiz_o(hiz), .park_low_o(low)
  );

  // behavioural reference model
  bit        m_done;
  bit        m_fs, m_en;
  bit [1:0]  m_strap, m_sw, m_mode;
  bit [11:0] m_oe;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_done = 0; m_fs = 0; m_strap = 0; m_sw = 2'b11; m_en = 0;
      m_oe = 12'hFFF; m_mode = 0;
    end else begin
      if (!m_done) begin
        m_done = 1; m_fs = s_fs; m_strap = s_mode; m_mode = s_mode;
      end else if (warm) begin
        m_mode = m_en ? m_sw : m_strap;
      end
      if (we) begin
        case (addr)
          2'd0: begin m_sw = wdata[2:1]; m_en = wdata[3]; end
          2'd1: m_oe[7:0] = wdata;
          2'd2: m_oe[11:8] = wdata[3:0];
          default: ;
        endcase
      end
    end
  end

  function automatic bit [7:0] model_rd(input bit [1:0] a);
    case (a)
      2'd0: return {m_strap, 2'b00, m_en, m_sw, m_fs};
      2'd1: return m_oe[7:0];
      2'd2: return {4'h0, m_oe[11:8]};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h @%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) if (!finished) begin
    check(fs_o == m_fs, "R2 fs_sel_o", fs_o, m_fs);
    check(mode_o == m_mode, "R6 pll_mode_o", mode_o, m_mode);
    check(oe == m_oe, "R8 oe_o", oe, m_oe);
    check(hiz == ~m_oe && low == 12'h0, "R9 park", {low, hiz}, {12'h0, ~m_oe});
    check(rdata == model_rd(addr), "R7 reg_rdata_o", rdata, model_rd(addr));
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic wr(input bit [1:0] a, input bit [7:0] d);
    addr = a; wdata = d; we = 1; tick(); we = 0;
  endtask

  task automatic rd_chk(input bit [1:0] a, input bit [7:0] exp, input string req);
    addr = a; #1;
    check(rdata == exp, req, rdata, exp);
  endtask

  task automatic pulse_warm();
    warm = 1; tick(); warm = 0;
  endtask

  initial begin
    s_fs = 1; s_mode = 2'b10;
    tick(3);
    rd_chk(2'd1, 8'hFF, "R1 reset oe");
    check(oe == 12'hFFF, "R1 reset oe_o", oe, 12'hFFF);
    rst_n = 1;
    tick();                        // capture edge
    s_fs = 0; s_mode = 2'b01;      // pins move after capture
    tick(2);
    // R1 R3 R4: defaults, captured straps
    rd_chk(2'd0, 8'h87, "R3 capture readback");
    check(mode_o == 2'b10, "R6 mode from strap", mode_o, 2'b10);
    check(fs_o == 1'b1, "R2 fs latched", fs_o, 1);
    // R5 R2 R4: read-only and reserved bits ignore writes
    wr(2'd0, 8'hFF);
    rd_chk(2'd0, 8'h8F, "R5 ro/reserved ignored");
    check(mode_o == 2'b10, "R6 mode held w/o warm", mode_o, 2'b10);
    tick(3);
    check(mode_o == 2'b10, "R6 mode still held", mode_o, 2'b10);
    pulse_warm();
    check(mode_o == 2'b11, "R6 override applied", mode_o, 2'b11);
    rd_chk(2'd0, 8'h8F, "R4 strap kept under override");
    // R7: software mode 01, override disabled
    wr(2'd0, 8'h02);
    rd_chk(2'd0, 8'h83, "R7 readback");
    check(mode_o == 2'b11, "R6 held after write", mode_o, 2'b11);
    pulse_warm();
    check(mode_o == 2'b10, "R6 back to strap", mode_o, 2'b10);
    wr(2'd0, 8'h0A);
    pulse_warm();
    check(mode_o == 2'b01, "R6 sw mode 01", mode_o, 2'b01);
    // R8 R9
    wr(2'd1, 8'h5A);
    wr(2'd2, 8'hF3);
    rd_chk(2'd2, 8'h03, "R5 reg2 reserved");
    check(oe == 12'h35A, "R8 oe map", oe, 12'h35A);
    check(hiz == 12'hCA5, "R9 hiz", hiz, 12'hCA5);
    check(low == 12'h000, "R9 low", low, 0);
    wr(2'd3, 8'hFF);
    rd_chk(2'd3, 8'h00, "R5 addr3");
    check(oe == 12'h35A, "R5 addr3 no effect", oe, 12'h35A);
    // random phase
    for (int i = 0; i < 400; i++) begin
      we = $urandom_range(0, 1); addr = 2'($urandom_range(0, 3));
      wdata = 8'($urandom); warm = ($urandom_range(0, 3) == 0);
      s_fs = 1'($urandom); s_mode = 2'($urandom);
      tick();
    end
    we = 0; warm = 0;
    // second power-on reset with other straps
    rst_n = 0; s_fs = 0; s_mode = 2'b01;
    tick(2);
    rd_chk(2'd0, 8'h06, "R1 defaults in reset");
    rst_n = 1;
    tick();
    s_fs = 1; s_mode = 2'b11;
    tick();
    rd_chk(2'd0, 8'h46, "R3 recapture");
    check(mode_o == 2'b01, "R6 recapture mode", mode_o, 2'b01);
    check(fs_o == 1'b0, "R2 fs 133", fs_o, 0);
    tick(2);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule